// File: doc/BRIEF.md
# Pipelined Cubic Horner Evaluator

This block evaluates a third-order polynomial at a point x that stays fixed over a whole stream of samples. Each sample is a set of four signed coefficients. The block computes the value in nested multiply-add form, so it needs three multiply-add cells and never forms x squared or x cubed on its own. A register follows each cell.

The two lower-order coefficients are held back by one and two cycles. Each one therefore reaches its cell in the same cycle as the partial sum it joins. A fresh coefficient set can enter on every clock, and every result leaves exactly three cycles after its set was taken in.

The point x is stored in a register that changes only when a load strobe is given. All arithmetic is two's-complement at a parameterised word width. Each cell keeps only the low bits of its product and sum, so the block behaves as arithmetic modulo 2^W.

Top module: `horner_cubic_pipe`

## Requirements
- R1: When a coefficient set (coef0..coef3) is accepted, `result` later equals coef0 + coef1·x + coef2·x² + coef3·x³ reduced modulo 2^W and read as W-bit two's complement. Here x is the value held in the x register. The block forms it in the nested order coef0 + x·(coef1 + x·(coef2 + x·coef3)).
- R2: A set is accepted on a rising edge where `in_valid` is 1. `out_valid` is 1 with its result after exactly the third rising edge from and including that one, and not before.
- R3: A new set can be accepted on every consecutive edge. Back-to-back sets come out on consecutive cycles, in input order.
- R4: The x register takes `x_in` on an edge where `x_load` is 1. At all other times it holds its value, and changes on `x_in` have no effect on results.
- R5: A synchronous active-high `rst` clears every valid stage. After a reset edge `out_valid` is 0, and sets that were in flight produce no output.
- R6: The word width W is a parameter (default 18). Products and sums that exceed W bits wrap, keeping the low W bits.
- R7: An edge with `in_valid` at 0 inserts a bubble. `out_valid` is 0 three edges later, and the neighbouring sets keep their correct results.
- R8: `x_load` may be raised only when no set is in flight and `in_valid` is 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| x_load | input | 1 | Strobe that loads `x_in` into the x register |
| x_in | input | W | Evaluation point, signed |
| in_valid | input | 1 | Marks the coefficient set as valid this cycle |
| coef0 | input | W | Constant term, signed |
| coef1 | input | W | Linear coefficient, signed |
| coef2 | input | W | Quadratic coefficient, signed |
| coef3 | input | W | Cubic coefficient, signed |
| out_valid | output | 1 | Result on `result` is valid |
| result | output | W | Polynomial value modulo 2^W, signed |

## Verification
The checks on output value and timing assume that x does not change while a set is in the three stages. A separate property, tied to R8, flags any load that arrives while sets are in flight or in the same cycle as an accepted set. The stimulus obeys this rule. Every reload of x happens only after the earlier stream has fully drained and with `in_valid` low. After a reload, the next set starts on the following cycle at the earliest.

// File: rtl/horner_cubic_pipe.sv
module horner_cubic_pipe #(
  parameter int W = 18,
  localparam int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         x_load,
  input  logic [W-1:0] x_in,
  input  logic         in_valid,
  input  logic [W-1:0] coef0,
  input  logic [W-1:0] coef1,
  input  logic [W-1:0] coef2,
  input  logic [W-1:0] coef3,
  output logic         out_valid,
  output logic [W-1:0] result
);

  logic [W-1:0] x_q;
  logic [W-1:0] acc1, acc2, acc3;
  logic [W-1:0] c1_d1, c0_d1, c0_d2;
  logic [STAGES-1:0] vld;

  always_ff @(posedge clk)
    if (x_load) x_q <= x_in;

  always_ff @(posedge clk) begin
    acc1  <= coef3 * x_q + coef2;
    c1_d1 <= coef1;
    c0_d1 <= coef0;
    acc2  <= acc1 * x_q + c1_d1;
    c0_d2 <= c0_d1;
    acc3  <= acc2 * x_q + c0_d2;
  end

  always_ff @(posedge clk)
    if (rst) vld <= '0;
    else     vld <= {vld[STAGES-2:0], in_valid};

  assign out_valid = vld[STAGES-1];
  assign result    = acc3;

endmodule

// File: rtl/horner_cubic_pipe_chk.sv
module horner_cubic_pipe_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         x_load,
  input logic [W-1:0] x_in,
  input logic         in_valid,
  input logic [W-1:0] coef0,
  input logic [W-1:0] coef1,
  input logic [W-1:0] coef2,
  input logic [W-1:0] coef3,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic [W-1:0] x_q,
  input logic [2:0]   vld
);

  logic [1:0] since_rst = 2'd0;
  always_ff @(posedge clk)
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  function automatic logic [W-1:0] power_form(logic [W-1:0] a0, a1, a2, a3, xv);
    logic [W-1:0] x2, x3;
    x2 = xv * xv;
    x3 = x2 * xv;
    return a0 + a1 * xv + a2 * x2 + a3 * x3;
  endfunction

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r1_value: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid) |->
      (result == power_form($past(coef0, 3), $past(coef1, 3), $past(coef2, 3), $past(coef3, 3), x_q)));

  a_r4_x_hold: assert property (@(posedge clk) disable iff (rst)
    !x_load |=> $stable(x_q));

  a_r4_x_take: assert property (@(posedge clk) disable iff (rst)
    x_load |=> (x_q == $past(x_in)));

  a_r5_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  a_r8_load_when_empty: assert property (@(posedge clk) disable iff (rst)
    x_load |-> (vld == 3'b000 && !in_valid));

endmodule

bind horner_cubic_pipe horner_cubic_pipe_chk #(.W(W)) u_chk (.*);

// File: tb/sim_horner_cubic_pipe.sv
module sim_horner_cubic_pipe;
  localparam int W = 18;
  localparam int NROW = 8;
  localparam int TAB [0:NROW-1][0:3] = '{
    '{1, 2, 3, 4},
    '{0, 0, 0, 0},
    '{-7, 5, -3, 1},
    '{100, -200, 300, -400},
    '{131071, 131071, 131071, 131071},
    '{-131072, -131072, -131072, -131072},
    '{12345, -54321, 777, -2},
    '{-1, 1, -1, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_load = 1'b0;
  logic [W-1:0] x_in = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] coef0 = '0, coef1 = '0, coef2 = '0, coef3 = '0;
  logic out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  horner_cubic_pipe #(.W(W)) u0 (
    .clk(clk), .rst(rst), .x_load(x_load), .x_in(x_in), .in_valid(in_valid),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [W-1:0] model(int r, logic [W-1:0] xv);
    longint xs, s;
    logic [63:0] u;
    xs = longint'($signed(xv));
    s = longint'(TAB[r][0]) + longint'(TAB[r][1]) * xs
      + longint'(TAB[r][2]) * xs * xs + longint'(TAB[r][3]) * xs * xs * xs;
    u = s;
    return u[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_row(input bit v, input int r);
    in_valid = v;
    coef0 = W'(TAB[r][0]);
    coef1 = W'(TAB[r][1]);
    coef2 = W'(TAB[r][2]);
    coef3 = W'(TAB[r][3]);
  endtask

  task automatic load_x(input logic [W-1:0] xv);
    @(negedge clk);
    x_load = 1'b1;
    x_in = xv;
    @(negedge clk);
    x_load = 1'b0;
    x_in = ~xv;
  endtask

  task automatic stream(input logic [7:0] pat, input int n, input logic [W-1:0] xv, input string req);
    for (int i = 0; i <= n + 2; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check(out_valid == pat[i-3], {req, " valid"}, out_valid, pat[i-3]);
        if (pat[i-3])
          check(result == model((i-3) % NROW, xv), {req, " value"},
                longint'($signed(result)), longint'($signed(model((i-3) % NROW, xv))));
      end
      if (i < n) drive_row(pat[i], i % NROW);
      else drive_row(1'b0, 0);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R5 reset state", out_valid, 0);

    load_x(W'(3));

    // R2: a single set appears after the third edge and not before
    @(negedge clk);
    drive_row(1'b1, 2);
    @(negedge clk);
    drive_row(1'b0, 0);
    check(out_valid == 1'b0, "R2 early edge1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 early edge2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 latency valid", out_valid, 1);
    check(result == model(2, W'(3)), "R2 latency value", longint'($signed(result)),
          longint'($signed(model(2, W'(3)))));
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single pulse", out_valid, 0);

    // R1 R3 R6: back-to-back table rows, including wrapping corner rows
    stream(8'hFF, NROW, W'(3), "R1 R3 R6 stream x=3");

    // R7: bubbles in the stream
    stream(8'b0110_1101, NROW, W'(3), "R7 bubbles");

    // R4: x_in changes without a load have no effect
    @(negedge clk);
    x_in = W'(99);
    stream(8'h3F, 6, W'(3), "R4 no load ignored");

    // R4 R8: reload x while empty, then stream with negative x
    load_x(W'(-5));
    stream(8'hFF, NROW, W'(-5), "R4 reload x=-5");

    // R6: most negative x with full-scale coefficients
    load_x(W'(-131072));
    stream(8'hFF, NROW, W'(-131072), "R6 wrap x=min");

    // R5: reset drops sets in flight
    load_x(W'(7));
    @(negedge clk);
    drive_row(1'b1, 0);
    @(negedge clk);
    drive_row(1'b1, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive_row(1'b0, 0);
    for (int k = 0; k < 4; k++) begin
      check(out_valid == 1'b0, "R5 flush after reset", out_valid, 0);
      @(negedge clk);
    end

    // R1: pipeline usable again after reset
    stream(8'h0F, 4, W'(7), "R1 after reset x=7");

    summary();
  end
endmodule